// File: doc/BRIEF.md
# Quadrature-Offset Phase Accumulator with Sine Output

This block is a numerically controlled oscillator core. Two 32-bit tuning words are presented in parallel, and a select input picks one of them. When an active-low transfer strobe is seen, the picked word is moved into a step register. Every enabled clock, a 32-bit accumulator adds that step to its contents. The output frequency is therefore step·Fclk/2^32.

The top 13 bits of the accumulator form the phase. A 2-bit modulation code adds a multiple of a quarter turn to that phase, which allows direct QPSK driven by an I/Q bit pair. The phase then addresses a sine lookup. The lookup holds one quarter-wave table, computed at elaboration and unfolded by symmetry. Its result is registered as a 12-bit offset-binary sample.

Every control input passes through its own fixed pipeline delay. This makes a frequency change, a phase jump, a freeze or a phase reset land on a predictable output cycle.

Top module: `nco_qpsk`

## Requirements
- R1: While rst_n is low, and after it is released, sample is 0x800, the accumulator and step register hold 0, and every control pipeline holds its inactive value (strobes high, modulation code 00).
- R2: If xfer_n is low at rising edge k, the word picked at edge k (word_b when word_sel is 1, word_a when it is 0) enters the step register at edge k+3. The new frequency first shows in sample after edge k+5. Word or select changes after edge k do not alter what was captured.
- R3: On every enabled edge the accumulator becomes accumulator + step, modulo 2^32. Sample after edge t is computed from the accumulator value held just before edge t.
- R4: If run_n is high at edge k, the accumulator keeps its value at edge k+3. If run_n is low at edge k, the accumulator advances at edge k+3.
- R5: If load_n is low at edge k, the accumulator feedback is zero at edge k+4, provided run_n was low at edge k+1. The accumulator then takes the step value.
- R6: The pm code sampled at edge k is used by the output register at edge k+3. It adds a number of quarter turns to phase bits [12:11]: 00 adds 0 (0°), 01 adds 1 (90°), 11 adds 2 (180°) and 10 adds 3 (270°).
- R7: The 13-bit phase is accumulator bits [31:19] plus the quarter-turn offset, so that 0x1000 is 180°. Sample equals 0x800 + round(2047·sin(2π·phase/8192)) within ±1 LSB.
- R8: Sample stays within 0x001..0xFFF and never reads 0x000. It is exactly 0xFFF at phase 0x0800 and exactly 0x001 at phase 0x1800.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_a | input | 32 | Tuning word used when word_sel is 0 |
| word_b | input | 32 | Tuning word used when word_sel is 1 |
| word_sel | input | 1 | Picks word_b (1) or word_a (0) on a transfer |
| xfer_n | input | 1 | Active-low transfer of the picked word to the step register |
| load_n | input | 1 | Active-low zeroing of the accumulator feedback |
| run_n | input | 1 | Active-low accumulate enable; high freezes the accumulator |
| pm | input | 2 | Quadrature phase-modulation code |
| sample | output | 12 | Offset-binary sine sample |

## Verification
The bound checker is evaluated on every cycle. It checks the transfer latency against the port values four edges earlier, the freeze caused by run_n, the load of the step value after the combined load and enable delays, and the absence of a 0x000 sample.

Some behaviours can only be shown by the bench's scenarios, because the expected value comes from a real-valued sine model. These are the sample values themselves, the exact peak and trough codes, the modulation code-to-angle mapping, the output cycle on which a phase jump appears, and the long-run frequency under a non-trivial tuning word.

// File: rtl/nco_qpsk.sv
`timescale 1ns/1ps
module nco_qpsk #(
  parameter int ACC_W    = 32,
  parameter int PH_W     = 13,
  parameter int OUT_W    = 12,
  parameter int XFER_LAT = 4,
  parameter int LOAD_LAT = 5,
  parameter int RUN_LAT  = 4,
  parameter int PM_LAT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] word_a,
  input  logic [ACC_W-1:0] word_b,
  input  logic             word_sel,
  input  logic             xfer_n,
  input  logic             load_n,
  input  logic             run_n,
  input  logic [1:0]       pm,
  output logic [OUT_W-1:0] sample
);
  localparam int QW  = PH_W - 2;
  localparam int QN  = 1 << QW;
  localparam int MW  = OUT_W - 1;
  localparam int AMP = (1 << MW) - 1;
  localparam int MID = 1 << MW;

  function automatic int qsin(int i);
    real x, t, s;
    x = 3.14159265358979 * i / (2.0 * QN);
    t = x;
    s = x;
    for (int k = 1; k < 9; k++) begin
      t = -t * x * x / ((2.0 * k) * (2.0 * k + 1.0));
      s = s + t;
    end
    return $rtoi(s * AMP + 0.5);
  endfunction

  function automatic logic [1:0] quarters(logic [1:0] code);
    case (code)
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  logic             xf_q [XFER_LAT-1];
  logic [ACC_W-1:0] wd_q [XFER_LAT-1];
  logic             ld_q [LOAD_LAT-1];
  logic             rn_q [RUN_LAT-1];
  logic [1:0]       pm_q [PM_LAT-1];
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < XFER_LAT-1; i++) begin
        xf_q[i] <= 1'b1;
        wd_q[i] <= '0;
      end
      for (int i = 0; i < LOAD_LAT-1; i++) ld_q[i] <= 1'b1;
      for (int i = 0; i < RUN_LAT-1; i++)  rn_q[i] <= 1'b1;
      for (int i = 0; i < PM_LAT-1; i++)   pm_q[i] <= 2'b00;
    end else begin
      xf_q[0] <= xfer_n;
      wd_q[0] <= word_sel ? word_b : word_a;
      ld_q[0] <= load_n;
      rn_q[0] <= run_n;
      pm_q[0] <= pm;
      for (int i = 1; i < XFER_LAT-1; i++) begin
        xf_q[i] <= xf_q[i-1];
        wd_q[i] <= wd_q[i-1];
      end
      for (int i = 1; i < LOAD_LAT-1; i++) ld_q[i] <= ld_q[i-1];
      for (int i = 1; i < RUN_LAT-1; i++)  rn_q[i] <= rn_q[i-1];
      for (int i = 1; i < PM_LAT-1; i++)   pm_q[i] <= pm_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      acc  <= '0;
    end else begin
      if (!xf_q[XFER_LAT-2]) step <= wd_q[XFER_LAT-2];
      if (!rn_q[RUN_LAT-2])  acc  <= (ld_q[LOAD_LAT-2] ? acc : '0) + step;
    end
  end

  logic [MW-1:0] qtab [QN+1];
  for (genvar g = 0; g <= QN; g++) begin : g_qtab
    assign qtab[g] = MW'(qsin(g));
  end

  logic [PH_W-1:0]  phase;
  logic [QW:0]      fidx;
  logic [MW-1:0]    mag;
  logic [OUT_W-1:0] sample_d;

  assign phase    = acc[ACC_W-1 -: PH_W] + {quarters(pm_q[PM_LAT-2]), {QW{1'b0}}};
  assign fidx     = phase[PH_W-2] ? (QW+1)'(QN) - {1'b0, phase[QW-1:0]}
                                  : {1'b0, phase[QW-1:0]};
  assign mag      = qtab[fidx];
  assign sample_d = phase[PH_W-1] ? OUT_W'(MID) - {1'b0, mag}
                                  : OUT_W'(MID) + {1'b0, mag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample <= OUT_W'(MID);
    else        sample <= sample_d;
  end
endmodule

// File: rtl/nco_qpsk_chk.sv
`timescale 1ns/1ps
module nco_qpsk_chk #(
  parameter int ACC_W    = 32,
  parameter int OUT_W    = 12,
  parameter int XFER_LAT = 4,
  parameter int LOAD_LAT = 5,
  parameter int RUN_LAT  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] word_a,
  input logic [ACC_W-1:0] word_b,
  input logic             word_sel,
  input logic             xfer_n,
  input logic             load_n,
  input logic             run_n,
  input logic [OUT_W-1:0] sample,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] step
);
  logic [3:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end

  p_xfer_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= XFER_LAT && !$past(xfer_n, XFER_LAT))
      |-> step == $past(word_sel ? word_b : word_a, XFER_LAT));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= RUN_LAT && $past(run_n, RUN_LAT)) |-> acc == $past(acc));

  p_load_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= LOAD_LAT && !$past(load_n, LOAD_LAT) && !$past(run_n, RUN_LAT))
      |-> acc == $past(step));

  p_no_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample != '0);
endmodule

bind nco_qpsk nco_qpsk_chk #(
  .ACC_W(ACC_W), .OUT_W(OUT_W), .XFER_LAT(XFER_LAT),
  .LOAD_LAT(LOAD_LAT), .RUN_LAT(RUN_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_a(word_a), .word_b(word_b),
  .word_sel(word_sel), .xfer_n(xfer_n), .load_n(load_n), .run_n(run_n),
  .sample(sample), .acc(acc), .step(step)
);

// File: tb/nco_qpsk_test.sv
`timescale 1ns/1ps
module nco_qpsk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_a = '0, word_b = '0;
  logic        word_sel = 1'b0, xfer_n = 1'b1, load_n = 1'b1, run_n = 1'b0;
  logic [1:0]  pm = 2'b00;
  logic [11:0] sample;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  nco_qpsk uut (
    .clk(clk), .rst_n(rst_n), .word_a(word_a), .word_b(word_b),
    .word_sel(word_sel), .xfer_n(xfer_n), .load_n(load_n), .run_n(run_n),
    .pm(pm), .sample(sample)
  );

  function automatic int model(int ph);
    real v;
    v = 2047.0 * $sin(2.0 * 3.14159265358979 * ph / 8192.0);
    return 2048 + (v >= 0.0 ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5));
  endfunction

  task automatic check(string req, int got, int exp, int tol);
    n_checks++;
    if (got > exp + tol || got < exp - tol) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h (tol %0d) at %0t", req, got, exp, tol, $time);
    end
  endtask

  task automatic check_phase(string req, int ph);
    int exact;
    exact = ((ph % 8192) == 2048) || ((ph % 8192) == 6144);
    check(req, int'(sample), model(ph % 8192), exact ? 0 : 1);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    word_a = '0; word_b = '0; word_sel = 1'b0;
    xfer_n = 1'b1; load_n = 1'b1; run_n = 1'b0; pm = 2'b00;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic t_transfer();
    do_reset();
    check("R1 reset sample", int'(sample), 12'h800, 0);
    word_a = 32'h2000_0000; word_sel = 1'b0; xfer_n = 1'b0;
    tick(1);
    xfer_n = 1'b1; word_a = 32'h4000_0000;
    for (int k = 1; k <= 4; k++) begin
      tick(1);
      check("R2 not yet transferred", int'(sample), 12'h800, 0);
    end
    for (int k = 5; k <= 12; k++) begin
      tick(1);
      check_phase("R2 R3 R7 R8 eighth-turn steps", ((k - 4) * 1024) % 8192);
    end
  endtask

  task automatic t_select();
    do_reset();
    word_a = 32'h0100_0000; word_b = 32'h4000_0000; word_sel = 1'b1; xfer_n = 1'b0;
    tick(1);
    xfer_n = 1'b1; word_sel = 1'b0; word_b = '0;
    tick(4);
    check("R2 select latency", int'(sample), 12'h800, 0);
    tick(1); check_phase("R2 word_b chosen", 2048);
    tick(1); check_phase("R2 word_b chosen", 4096);
    tick(1); check_phase("R2 word_b chosen", 6144);
  endtask

  task automatic t_hold();
    do_reset();
    run_n = 1'b1; word_a = 32'h2000_0000; xfer_n = 1'b0;
    tick(1);
    xfer_n = 1'b1;
    tick(8);
    check("R4 frozen with step loaded", int'(sample), 12'h800, 0);
    run_n = 1'b0;
    tick(1);
    run_n = 1'b1;
    tick(2); check("R4 enable not yet active", int'(sample), 12'h800, 0);
    tick(1); check("R4 enable latency", int'(sample), 12'h800, 0);
    for (int k = 0; k < 3; k++) begin
      tick(1);
      check_phase("R4 single step then hold", 1024);
    end
  endtask

  task automatic t_load();
    do_reset();
    word_a = 32'h0100_0000; xfer_n = 1'b0;
    tick(1);
    xfer_n = 1'b1;
    tick(9);
    check_phase("R3 running phase", 160);
    load_n = 1'b0;
    tick(1);
    load_n = 1'b1;
    tick(4); check_phase("R5 load not yet active", 320);
    tick(1); check_phase("R5 load restarts at step", 32);
    tick(1); check_phase("R5 continues after load", 64);
  endtask

  task automatic t_pm();
    logic [1:0] codes [4];
    int         quarter [4];
    int         prev;
    codes[0] = 2'b01; quarter[0] = 1;
    codes[1] = 2'b11; quarter[1] = 2;
    codes[2] = 2'b10; quarter[2] = 3;
    codes[3] = 2'b00; quarter[3] = 0;
    do_reset();
    run_n = 1'b1; word_a = 32'h0100_0000; xfer_n = 1'b0;
    tick(1);
    xfer_n = 1'b1;
    tick(3);
    run_n = 1'b0;
    tick(1);
    run_n = 1'b1;
    tick(4);
    check_phase("R6 base phase code 00", 32);
    prev = 32;
    for (int c = 0; c < 4; c++) begin
      pm = codes[c];
      tick(3);
      check_phase("R6 modulation latency", prev);
      tick(1);
      prev = 32 + quarter[c] * 2048;
      check_phase("R6 quarter-turn coding", prev);
    end
  endtask

  task automatic t_sweep();
    logic [31:0] w, a;
    int zeros;
    do_reset();
    w = 32'h1234_5679;
    word_b = w; word_sel = 1'b1; xfer_n = 1'b0;
    tick(1);
    xfer_n = 1'b1;
    zeros = 0;
    for (int k = 1; k <= 300; k++) begin
      tick(1);
      a = (k >= 5) ? w * 32'(k - 4) : 32'h0;
      check_phase("R3 R7 frequency sweep", int'(a[31:19]));
      if (sample == 12'h000) zeros++;
    end
    check("R8 no zero code", zeros, 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_transfer();
    t_select();
    t_hold();
    t_load();
    t_pm();
    t_sweep();
    finish_run();
  end
endmodule